// File: doc/BRIEF.md
# Power-on self-test sequencer

This block takes control of a simple synchronous memory bus once, right after reset is released, and checks that the basic hardware answers. It runs three fixed stages in a fixed order. First it tests a bank of low RAM, then a bank of high RAM, then one peripheral register whose power-up value is known. Each RAM stage writes a byte pattern and its complement to two neighbouring locations and reads both back. The peripheral stage makes a single read and compares the result with the expected default.

The first stage that sees a wrong value ends the run. That stage's failure code is then latched and no later stage runs. If every stage passes, the block raises a pass flag, which the rest of the system uses to start a success tone and hand over to normal operation. Other blocks turn the code into LED blinks or sound. The results stay fixed until the next reset.

Each bus access holds address, data and strobe until the slave raises ready for one cycle. The slave may return ready in the same cycle the strobe appears, or it may add any number of wait cycles.

Top module: `post_sequencer`

## Requirements
- R1: While rst_n is low, bus_we, bus_re, done, pass and fail_code are all 0. The first access (a write of 0x55 to address 0x000000) is on the bus in the cycle after the first rising edge at which rst_n is high.
- R2: The low-RAM stage writes 0x55 to 0x000000 and 0xAA to 0x000001, then reads 0x000000 and then 0x000001, in that order.
- R3: The high-RAM stage uses bank byte 0x08 in address bits 23:16. It writes 0xAA to 0x080000 and 0x55 to 0x080001, then reads 0x080000 and then 0x080001.
- R4: The peripheral stage reads address 0x00C00E once and passes only if the value read is exactly 0x80.
- R5: An access keeps bus_addr, bus_wdata, bus_we and bus_re unchanged until a rising edge at which bus_ready is 1, and that edge completes the access. bus_we and bus_re are never both 1.
- R6: Both read-back bytes of a RAM stage are compared with the values written. A mismatch in either byte fails the stage, and the failure is reported after the stage's second read.
- R7: On failure, done goes to 1 with pass 0, and fail_code is 2 for the low-RAM stage, 3 for the high-RAM stage and 4 for the peripheral stage. No access of a later stage is issued.
- R8: When all three stages pass, done goes to 1 with pass 1 and fail_code 0. Before done, pass and fail_code are 0.
- R9: Once done is 1, done, pass and fail_code hold their values and the bus stays idle until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | output | 24 | Access address: bank byte in bits 23:16, offset below |
| bus_wdata | output | 8 | Write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_rdata | input | 8 | Read data, valid while bus_ready is 1 on a read |
| bus_ready | input | 1 | One-cycle completion of the pending access |
| done | output | 1 | Self-test finished |
| pass | output | 1 | All stages passed |
| fail_code | output | 3 | 0 while running or on pass; 2, 3 or 4 names the failed stage |

## Verification
The assertions assume that the slave raises bus_ready only while a strobe is pending. They also assume bus_rdata is settled whenever bus_ready is high during a read. Reset must be held for at least one rising edge so the quiet-state property has a defined start.

The bench's bus model follows these rules. It drives ready and read data only on falling edges, only in response to a strobe it sees, and with a random wait count between zero and a per-run limit. Stored RAM values and the peripheral register are corrupted only through read masks, so each fault shows up on the bus as a wrong read value.

// File: rtl/post_seq_pkg.sv
// Package: shared state type and stage failure codes for the power-on
// self-test sequencer. Assumes a 3-bit failure code.
package post_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_ARM  = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_t;

    localparam int CODE_W = 3;

    localparam logic [CODE_W-1:0] CODE_NONE = 3'd0;
    localparam logic [CODE_W-1:0] CODE_LO   = 3'd2;
    localparam logic [CODE_W-1:0] CODE_HI   = 3'd3;
    localparam logic [CODE_W-1:0] CODE_DEV  = 3'd4;

endpackage

// File: rtl/post_step_table.sv
// Module: post_step_table
// Maps a step index to one bus access. There are two RAM stages of
// RAM_STEPS steps each (write offset 0, write offset 1, read offset 0,
// read offset 1), then one peripheral read. Purely combinational.
// Assumes RAM_STEPS is 4 and offsets are the low bit of the step index.
module post_step_table
    import post_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int OFF_W  = 16,
    parameter int STEP_W = 4,
    parameter int RAM_STEPS = 4,
    parameter logic [ADDR_W-OFF_W-1:0] LO_BANK = 8'h00,
    parameter logic [ADDR_W-OFF_W-1:0] HI_BANK = 8'h08,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 24'h00C00E,
    parameter logic [DATA_W-1:0] DEV_EXPECT = 8'h80,
    parameter logic [DATA_W-1:0] PATTERN = 8'h55
) (
    input  logic [STEP_W-1:0] step_idx,
    output logic              step_wr,
    output logic [ADDR_W-1:0] step_addr,
    output logic [DATA_W-1:0] step_byte,
    output logic              step_stage_end,
    output logic              step_final,
    output logic [CODE_W-1:0] step_code
);

    logic              in_dev;
    logic              in_hi;
    logic [1:0]        sub;
    logic [DATA_W-1:0] base;

    // Decode stage and position within the stage, then build the access.
    always_comb begin
        in_dev = (step_idx >= STEP_W'(2 * RAM_STEPS));
        in_hi  = !in_dev && (step_idx >= STEP_W'(RAM_STEPS));
        sub    = step_idx[1:0];
        base   = in_hi ? ~PATTERN : PATTERN;

        step_wr        = !in_dev && !sub[1];
        step_stage_end = in_dev || (sub == 2'd3);
        step_final     = in_dev;

        if (in_dev) begin
            step_addr = DEV_ADDR;
            step_byte = DEV_EXPECT;
            step_code = CODE_DEV;
        end else begin
            step_addr = {(in_hi ? HI_BANK : LO_BANK), OFF_W'(sub[0])};
            step_byte = sub[0] ? ~base : base;
            step_code = in_hi ? CODE_HI : CODE_LO;
        end
    end

endmodule

// File: rtl/post_read_check.sv
// Module: post_read_check
// Accumulates read-back mismatches within one stage. stage_bad includes the
// read that completes in the current cycle. The accumulator is cleared when
// the stage ends. Assumes capture is high only on completed reads.
module post_read_check #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              clear,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] expect_byte,
    output logic              stage_bad
);

    logic acc_bad;
    logic hit_bad;

    // Flag a mismatch on the read completing now.
    always_comb begin
        hit_bad   = capture && (rdata != expect_byte);
        stage_bad = acc_bad || hit_bad;
    end

    // Keep earlier mismatches of the stage until the stage closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_bad <= 1'b0;
        end else if (clear) begin
            acc_bad <= 1'b0;
        end else if (hit_bad) begin
            acc_bad <= 1'b1;
        end
    end

endmodule

// File: rtl/post_result_reg.sv
// Module: post_result_reg
// Holds the final outcome. The first finish pulse after reset latches
// done, pass and the code; they then stay fixed until reset.
module post_result_reg
    import post_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              finish,
    input  logic              pass_in,
    input  logic [CODE_W-1:0] code_in,
    output logic              done,
    output logic              pass,
    output logic [CODE_W-1:0] fail_code
);

    // Latch the outcome once and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            pass      <= 1'b0;
            fail_code <= CODE_NONE;
        end else if (finish && !done) begin
            done      <= 1'b1;
            pass      <= pass_in;
            fail_code <= pass_in ? CODE_NONE : code_in;
        end
    end

endmodule

// File: rtl/post_sequencer.sv
// Module: post_sequencer (top)
// Runs the power-on self-test once after reset: low RAM, high RAM, then the
// peripheral register. Access completion is taken from bus_ready. The
// sequence stops at the first failing stage. Assumes the slave asserts
// bus_ready only while a strobe is pending.
module post_sequencer
    import post_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int OFF_W  = 16,
    parameter logic [ADDR_W-OFF_W-1:0] LO_BANK = 8'h00,
    parameter logic [ADDR_W-OFF_W-1:0] HI_BANK = 8'h08,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 24'h00C00E,
    parameter logic [DATA_W-1:0] DEV_EXPECT = 8'h80,
    parameter logic [DATA_W-1:0] PATTERN = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    output logic              done,
    output logic              pass,
    output logic [2:0]        fail_code
);

    localparam int RAM_STEPS = 4;
    localparam int N_STEPS   = 2 * RAM_STEPS + 1;
    localparam int STEP_W    = $clog2(N_STEPS);

    seq_state_t        state;
    logic [STEP_W-1:0] step;
    logic              step_wr;
    logic [ADDR_W-1:0] step_addr;
    logic [DATA_W-1:0] step_byte;
    logic              step_stage_end;
    logic              step_final;
    logic [CODE_W-1:0] step_code;
    logic              running;
    logic              completes;
    logic              stage_bad;
    logic              finish;

    post_step_table #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .STEP_W(STEP_W),
        .RAM_STEPS(RAM_STEPS), .LO_BANK(LO_BANK), .HI_BANK(HI_BANK),
        .DEV_ADDR(DEV_ADDR), .DEV_EXPECT(DEV_EXPECT), .PATTERN(PATTERN)
    ) u_table (
        .step_idx       (step),
        .step_wr        (step_wr),
        .step_addr      (step_addr),
        .step_byte      (step_byte),
        .step_stage_end (step_stage_end),
        .step_final     (step_final),
        .step_code      (step_code)
    );

    post_read_check #(.DATA_W(DATA_W)) u_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (completes && !step_wr),
        .clear       (completes && step_stage_end),
        .rdata       (bus_rdata),
        .expect_byte (step_byte),
        .stage_bad   (stage_bad)
    );

    post_result_reg u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .finish    (finish),
        .pass_in   (!stage_bad),
        .code_in   (step_code),
        .done      (done),
        .pass      (pass),
        .fail_code (fail_code)
    );

    // Drive the bus from the current step while running; idle otherwise.
    always_comb begin
        running   = (state == SEQ_RUN);
        completes = running && bus_ready;
        finish    = completes && step_stage_end && (stage_bad || step_final);
        bus_we    = running && step_wr;
        bus_re    = running && !step_wr;
        bus_addr  = running ? step_addr : '0;
        bus_wdata = (running && step_wr) ? step_byte : '0;
    end

    // Step through the accesses; stop on a failing stage or after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_ARM;
            step  <= '0;
        end else begin
            case (state)
                SEQ_ARM: state <= SEQ_RUN;
                SEQ_RUN: begin
                    if (finish) begin
                        state <= SEQ_DONE;
                    end else if (completes) begin
                        step <= step + STEP_W'(1);
                    end
                end
                default: state <= SEQ_DONE;
            endcase
        end
    end

endmodule

// File: rtl/post_sequencer_chk.sv
// Module: post_sequencer_chk
// Property checker for post_sequencer, attached with bind. Assumes the
// slave raises bus_ready only while a strobe is pending.
module post_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [23:0] bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        bus_we,
    input logic        bus_re,
    input logic        bus_ready,
    input logic        done,
    input logic        pass,
    input logic [2:0]  fail_code
);

    // R1: reset leaves the bus and results quiet.
    p_quiet_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!bus_we && !bus_re && !done && !pass && fail_code == 3'd0));

    // R5: a pending access holds its address, data and strobes until ready.
    p_hold_until_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_we || bus_re) && !bus_ready) |=>
        ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we) && $stable(bus_re)));

    // R5: never a read and a write together.
    p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));

    // R7: a failure carries one of the stage codes.
    p_fail_code_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> (fail_code >= 3'd2 && fail_code <= 3'd4));

    // R8: pass carries a zero code, and nothing shows before done.
    p_pass_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (fail_code == 3'd0));

    p_no_early_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!pass && fail_code == 3'd0));

    // R9: results hold and the bus stays idle after done.
    p_sticky_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(pass) && $stable(fail_code)));

    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_we && !bus_re));

endmodule

bind post_sequencer post_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_ready (bus_ready),
    .done      (done),
    .pass      (pass),
    .fail_code (fail_code)
);

// File: tb/tb_post_sequencer.sv
// Bench for post_sequencer: a bus model with random wait states and
// injectable read faults, and directed and random fault cases. Expected
// results come from bench functions.
module tb_post_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_we;
    logic        bus_re;
    logic [7:0]  bus_rdata = 8'h00;
    logic        bus_ready = 1'b0;
    logic        done;
    logic        pass;
    logic [2:0]  fail_code;

    always #2 clk = ~clk;

    post_sequencer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .done(done), .pass(pass), .fail_code(fail_code)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Bus model state
    logic [7:0]  lo_mem [2];
    logic [7:0]  hi_mem [2];
    logic [7:0]  lo_mask [2];
    logic [7:0]  hi_mask [2];
    logic [7:0]  dev_val;
    int          max_wait = 0;
    int          wait_left = 0;
    logic        cap_we;
    logic [23:0] cap_addr;
    logic [7:0]  cap_data;
    logic        prev_wait = 1'b0;
    logic [23:0] prev_addr;
    logic        log_we   [16];
    logic [23:0] log_addr [16];
    logic [7:0]  log_data [16];
    int          log_n = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [23:0] a);
        case (a)
            24'h000000: return lo_mem[0] ^ lo_mask[0];
            24'h000001: return lo_mem[1] ^ lo_mask[1];
            24'h080000: return hi_mem[0] ^ hi_mask[0];
            24'h080001: return hi_mem[1] ^ hi_mask[1];
            24'h00C00E: return dev_val;
            default:    return 8'h00;
        endcase
    endfunction

    // Expected access list, from R2, R3 and R4
    function automatic logic [23:0] exp_addr(input int i);
        if (i == 8) return 24'h00C00E;
        return {(i >= 4) ? 8'h08 : 8'h00, 15'd0, i[0]};
    endfunction

    function automatic logic exp_we(input int i);
        return (i < 8) && (i % 4 < 2);
    endfunction

    function automatic logic [7:0] exp_data(input int i);
        logic [7:0] b;
        b = (i >= 4) ? 8'hAA : 8'h55;
        return i[0] ? ~b : b;
    endfunction

    // Outcome from R6, R7 and R8
    function automatic int exp_code();
        if (lo_mask[0] != 0 || lo_mask[1] != 0) return 2;
        if (hi_mask[0] != 0 || hi_mask[1] != 0) return 3;
        if (dev_val != 8'h80) return 4;
        return 0;
    endfunction

    function automatic int exp_len(input int code);
        if (code == 2) return 4;
        if (code == 3) return 8;
        return 9;
    endfunction

    // Bus slave: drives ready and read data on falling edges and logs completed accesses.
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ready) begin
                if (log_n < 16) begin
                    log_we[log_n] = cap_we;
                    log_addr[log_n] = cap_addr;
                    log_data[log_n] = cap_data;
                end
                log_n++;
                if (cap_we) begin
                    if (cap_addr[23:1] == 23'h0) lo_mem[cap_addr[0]] = cap_data;
                    if (cap_addr[23:1] == 23'h040000) hi_mem[cap_addr[0]] = cap_data;
                end
                prev_wait = 1'b0;
            end
            bus_ready = 1'b0;
            if (rst_n && (bus_we || bus_re)) begin
                chk(!(bus_we && bus_re), "R5", "both strobes", 1, 0);
                if (prev_wait)
                    chk(bus_addr == prev_addr, "R5", "addr moved while waiting",
                        int'(bus_addr), int'(prev_addr));
                if (wait_left == 0) begin
                    bus_ready = 1'b1;
                    cap_we = bus_we;
                    cap_addr = bus_addr;
                    cap_data = bus_we ? bus_wdata : model_read(bus_addr);
                    bus_rdata = bus_we ? 8'h00 : cap_data;
                    wait_left = (max_wait == 0) ? 0 : int'($urandom_range(max_wait, 0));
                    prev_wait = 1'b0;
                end else begin
                    wait_left--;
                    prev_wait = 1'b1;
                    prev_addr = bus_addr;
                end
            end
        end
    end

    task automatic run_case(input logic [7:0] lm0, input logic [7:0] lm1,
                            input logic [7:0] hm0, input logic [7:0] hm1,
                            input logic [7:0] dv, input int mw);
        int code;
        int cyc;
        int len;
        logic sd;
        logic sp;
        logic [2:0] sc;
        int sn;
        string rq;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        lo_mask[0] = lm0; lo_mask[1] = lm1; hi_mask[0] = hm0; hi_mask[1] = hm1;
        dev_val = dv; max_wait = mw; wait_left = 0; log_n = 0; prev_wait = 1'b0;
        lo_mem[0] = 8'($urandom); lo_mem[1] = 8'($urandom);
        hi_mem[0] = 8'($urandom); hi_mem[1] = 8'($urandom);
        code = exp_code();
        len = exp_len(code);
        // R1: quiet during reset
        chk(!done && !pass && fail_code == 0 && !bus_we && !bus_re, "R1",
            "outputs in reset", {done, pass, fail_code, bus_we, bus_re}, 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(bus_we && bus_addr == 24'h0 && bus_wdata == 8'h55, "R1",
            "first access addr", int'(bus_addr), 0);
        cyc = 0;
        while (!done && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
        chk(done, "R7", "done timeout", int'(done), 1);
        repeat (2) @(negedge clk);
        if (code == 0)
            chk(pass && fail_code == 0, "R8", "pass result", {pass, fail_code}, 8);
        else
            chk(!pass && fail_code == 3'(code), "R7", "fail code",
                {pass, fail_code}, code);
        chk(log_n == len, "R7", "access count", log_n, len);
        for (int i = 0; i < len && i < log_n; i++) begin
            rq = (i < 4) ? "R2" : ((i < 8) ? "R3" : "R4");
            chk(log_addr[i] == exp_addr(i) && log_we[i] == exp_we(i), rq,
                "access addr/kind", int'({log_we[i], log_addr[i]}),
                int'({exp_we(i), exp_addr(i)}));
            if (exp_we(i))
                chk(log_data[i] == exp_data(i), rq, "write data",
                    int'(log_data[i]), int'(exp_data(i)));
        end
        sd = done; sp = pass; sc = fail_code; sn = log_n;
        repeat (6) @(negedge clk);
        chk(done == sd && pass == sp && fail_code == sc && log_n == sn &&
            !bus_we && !bus_re, "R9", "hold after done",
            {done, pass, fail_code, log_n}, {sd, sp, sc, sn});
    endtask

    initial begin
        void'($urandom(32'd4242));
        lo_mask[0] = 0; lo_mask[1] = 0; hi_mask[0] = 0; hi_mask[1] = 0;
        dev_val = 8'h80;
        // Directed: all pass, zero wait and with waits (R8, R5)
        run_case(0, 0, 0, 0, 8'h80, 0);
        run_case(0, 0, 0, 0, 8'h80, 3);
        // R6: a mismatch in either byte of a stage
        run_case(8'h01, 0, 0, 0, 8'h80, 0);
        run_case(0, 8'h80, 0, 0, 8'h80, 2);
        run_case(0, 0, 8'hFF, 0, 8'h80, 1);
        run_case(0, 0, 0, 8'h10, 8'h80, 0);
        // R4: near-miss peripheral values
        run_case(0, 0, 0, 0, 8'h00, 0);
        run_case(0, 0, 0, 0, 8'h81, 2);
        run_case(0, 0, 0, 0, 8'hC0, 0);
        // R7: earlier stage wins when several are faulty
        run_case(8'h04, 0, 8'h02, 0, 8'h00, 1);
        // Random cases
        for (int k = 0; k < 16; k++) begin
            logic [7:0] m [4];
            logic [7:0] d;
            for (int j = 0; j < 4; j++)
                m[j] = ($urandom_range(5, 0) == 0) ? 8'($urandom_range(255, 1)) : 8'h00;
            d = ($urandom_range(3, 0) == 0) ? 8'($urandom) : 8'h80;
            run_case(m[0], m[1], m[2], m[3], d, int'($urandom_range(4, 0)));
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule